// File: doc/BRIEF.md
# Serial fast command receiver

The block takes 16-bit control words from one asynchronous serial line and turns them into single-cycle control strobes. Each frame has a start bit, sixteen data bits and two stop bits. The bit period is set by a parameter counted in system clock cycles. A small fixed command set is decoded: begin acquisition, end acquisition, phase sync, transmit hold and transmit resume. All other words produce no action.

A free-running divider makes a periodic clock enable from the system clock. The sync command restarts the divider, so that every unit that receives the same command on the same line produces its enable in the same phase. The hold command raises a "do not send" flag. The flag drops by itself after a programmable number of cycles, or at once when a resume command arrives. A frame whose stop bits are not both high is dropped, and the block reports it with a framing-error strobe.

Top module: `fcmd_rx`

## Requirements
- R1: The line idles high. A frame is one low start bit, then 16 data bits with the least significant bit first, then two high stop bits, with no parity bit. Each bit lasts BIT_CYCLES clocks.
- R2: Word 0xE311 raises `acq_start_o` for exactly one cycle. It goes high on the rising edge that comes 18*BIT_CYCLES + BIT_CYCLES/2 + 3 cycles after the first edge at which `rx_i` is seen low. All other strobes use the same latency.
- R3: Word 0xE313 raises `acq_stop_o` for one cycle.
- R4: `ce_o` is high for one cycle in every DIV_CYCLES cycles. Word 0xE000 raises `sync_o` for one cycle and restarts the divider, so the next `ce_o` comes exactly DIV_CYCLES cycles after the `sync_o` cycle.
- R5: Word 0xE519 sets `hold_o` for exactly HOLD_CYCLES cycles, starting in the cycle where a strobe for that frame would appear. A further 0xE519 restarts the full interval.
- R6: Word 0xE51A clears `hold_o` in the cycle where its strobe would appear.
- R7: Word 0x0000 is accepted and has no effect. It produces no strobe and leaves `hold_o` and the `ce_o` phase unchanged.
- R8: Any other word produces no strobe and no change to `hold_o` or the `ce_o` phase.
- R9: If either stop bit is sampled low, `frame_err_o` pulses for one cycle at the strobe latency, and the word is discarded.
- R10: A low pulse that is no longer low at the middle of the start bit is ignored.
- R11: While `rst_ni` is low, all outputs are low. After release, the first `ce_o` comes DIV_CYCLES-1 cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial command line, idles high |
| acq_start_o | output | 1 | Begin-acquisition strobe |
| acq_stop_o | output | 1 | End-acquisition strobe |
| sync_o | output | 1 | Phase-sync strobe |
| hold_o | output | 1 | Do-not-send flag |
| ce_o | output | 1 | Divided clock enable |
| frame_err_o | output | 1 | Framing-error strobe |

## Verification
A bit counter that is off by one moves the sampling point. This shows up within one frame, as a wrong or missing strobe at a latency that no longer matches the expected value. A divider that fails to restart on sync, or that drifts, puts `ce_o` in the wrong cycle within DIV_CYCLES cycles of the sync strobe. A hold timer that fails to reload, or that stops too early or too late, shows up as a `hold_o` edge in the wrong cycle. The bench checks this against the expected end cycle, both for a single hold command and for a repeated one. Because every output is compared on every cycle, each of these faults is reported in the first cycle where it shows.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int WORD_BITS = 16;
  localparam int STOP_BITS = 2;
  localparam int NUM_STROBES = 3;

  localparam logic [WORD_BITS-1:0] CMD_ACQ_START  = 16'hE311;
  localparam logic [WORD_BITS-1:0] CMD_ACQ_STOP   = 16'hE313;
  localparam logic [WORD_BITS-1:0] CMD_SYNC       = 16'hE000;
  localparam logic [WORD_BITS-1:0] CMD_FLOW_STOP  = 16'hE519;
  localparam logic [WORD_BITS-1:0] CMD_FLOW_GO    = 16'hE51A;
  localparam logic [WORD_BITS-1:0] CMD_LEGACY_CLR = 16'h0000;

  // strobe index 0: start, 1: stop, 2: sync
  localparam logic [NUM_STROBES-1:0][WORD_BITS-1:0] STROBE_CODES =
    {CMD_SYNC, CMD_ACQ_STOP, CMD_ACQ_START};

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/fcmd_frame_rx.sv
module fcmd_frame_rx
  import fcmd_pkg::*;
#(
  parameter int BIT_CYCLES = 25
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic                 word_vld_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 frame_err_o
);
  localparam int HALF = BIT_CYCLES / 2;
  localparam int CW   = $clog2(BIT_CYCLES + 1);
  localparam int IW   = $clog2(WORD_BITS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [IW-1:0] DATA_LAST = IW'(WORD_BITS - 1);
  localparam logic [IW-1:0] STOP_LAST = IW'(STOP_BITS - 1);

  logic [1:0]           sync_q;
  logic                 rx_s;
  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic [WORD_BITS-1:0] shift_q;
  logic                 stop_bad_q;

  assign rx_s   = sync_q[1];
  assign word_o = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shift_q     <= '0;
      stop_bad_q  <= 1'b0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q      <= '0;
            idx_q      <= '0;
            stop_bad_q <= 1'b0;
            state_q    <= rx_s ? RX_IDLE : RX_DATA;  // reject glitches
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[WORD_BITS-1:1]};  // lsb first
            if (idx_q == DATA_LAST) begin
              idx_q   <= '0;
              state_q <= RX_STOP;
            end else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q <= '0;
            if (idx_q == STOP_LAST) begin
              state_q     <= RX_IDLE;
              word_vld_o  <= !stop_bad_q && rx_s;
              frame_err_o <= stop_bad_q || !rx_s;
            end else begin
              idx_q      <= idx_q + 1'b1;
              stop_bad_q <= stop_bad_q | !rx_s;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcmd_cmd_decode.sv
module fcmd_cmd_decode
  import fcmd_pkg::*;
#(
  parameter int HOLD_CYCLES = 125000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   word_vld_i,
  input  logic [WORD_BITS-1:0]   word_i,
  input  logic                   frame_err_i,
  output logic [NUM_STROBES-1:0] strobe_o,
  output logic                   frame_err_o,
  output logic                   hold_o
);
  localparam int TW = $clog2(HOLD_CYCLES + 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYCLES - 1);

  logic [TW-1:0] tmr_q;
  logic          hit_stop, hit_go;

  // legacy clear word (0x0000) matches no entry and is dropped here
  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_o[g] <= 1'b0;
      else         strobe_o[g] <= word_vld_i && (word_i == STROBE_CODES[g]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_err_o <= 1'b0;
    else         frame_err_o <= frame_err_i;
  end

  assign hit_stop = word_vld_i && (word_i == CMD_FLOW_STOP);
  assign hit_go   = word_vld_i && (word_i == CMD_FLOW_GO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      tmr_q  <= '0;
    end else if (hit_stop) begin
      hold_o <= 1'b1;
      tmr_q  <= HOLD_LAST;
    end else if (hit_go) begin
      hold_o <= 1'b0;
      tmr_q  <= '0;
    end else if (hold_o) begin
      if (tmr_q == '0) hold_o <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end
endmodule

// File: rtl/fcmd_ce_div.sv
module fcmd_ce_div #(
  parameter int DIV_CYCLES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic realign_i,
  output logic ce_o
);
  localparam int CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (realign_i)             cnt_q <= '0;
    else if (cnt_q == DIV_LAST)     cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = rst_ni && (cnt_q == DIV_LAST);
endmodule

// File: rtl/fcmd_rx.sv
module fcmd_rx
  import fcmd_pkg::*;
#(
  parameter int BIT_CYCLES  = 25,
  parameter int DIV_CYCLES  = 25,
  parameter int HOLD_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic acq_start_o,
  output logic acq_stop_o,
  output logic sync_o,
  output logic hold_o,
  output logic ce_o,
  output logic frame_err_o
);
  logic                   word_vld;
  logic [WORD_BITS-1:0]   word_q;
  logic                   rx_ferr;
  logic [NUM_STROBES-1:0] strobe;

  fcmd_frame_rx #(.BIT_CYCLES(BIT_CYCLES)) i_frame_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .word_vld_o (word_vld),
    .word_o     (word_q),
    .frame_err_o(rx_ferr)
  );

  fcmd_cmd_decode #(.HOLD_CYCLES(HOLD_CYCLES)) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_vld_i (word_vld),
    .word_i     (word_q),
    .frame_err_i(rx_ferr),
    .strobe_o   (strobe),
    .frame_err_o(frame_err_o),
    .hold_o     (hold_o)
  );

  fcmd_ce_div #(.DIV_CYCLES(DIV_CYCLES)) i_ce_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .realign_i(strobe[2]),
    .ce_o     (ce_o)
  );

  assign acq_start_o = strobe[0];
  assign acq_stop_o  = strobe[1];
  assign sync_o      = strobe[2];
endmodule

// File: rtl/fcmd_rx_chk.sv
module fcmd_rx_chk
  import fcmd_pkg::*;
#(
  parameter int DIV_CYCLES = 25
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 word_vld,
  input logic [WORD_BITS-1:0] word_q,
  input logic                 acq_start_o,
  input logic                 acq_stop_o,
  input logic                 sync_o,
  input logic                 hold_o,
  input logic                 ce_o,
  input logic                 frame_err_o
);
  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acq_start_o, acq_stop_o, sync_o, frame_err_o}));

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |=> !acq_start_o);

  assert_stop_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word_q == CMD_ACQ_STOP) |=> acq_stop_o);

  assert_sync_realign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIV_CYCLES > 1) && sync_o |=> !ce_o);

  assert_ce_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIV_CYCLES > 1) && ce_o |=> !ce_o);

  assert_hold_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word_q == CMD_FLOW_STOP) |=> hold_o);

  assert_hold_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word_q == CMD_FLOW_GO) |=> !hold_o);

  assert_legacy_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word_q == CMD_LEGACY_CLR) |=> !(acq_start_o || acq_stop_o || sync_o));

  assert_ferr_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !$past(word_vld));
endmodule

bind fcmd_rx fcmd_rx_chk #(.DIV_CYCLES(DIV_CYCLES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_vld   (word_vld),
  .word_q     (word_q),
  .acq_start_o(acq_start_o),
  .acq_stop_o (acq_stop_o),
  .sync_o     (sync_o),
  .hold_o     (hold_o),
  .ce_o       (ce_o),
  .frame_err_o(frame_err_o)
);

// File: tb/test_fcmd_rx.sv
module test_fcmd_rx;
  localparam int BIT  = 8;
  localparam int DIV  = 5;
  localparam int HOLD = 300;
  localparam int HALF = BIT / 2;
  localparam int LAT  = 4 + HALF + 18 * BIT;  // drive cycle -> strobe cycle
  localparam int GAP  = 6;
  localparam int WD   = 100000;

  localparam int K_NONE = 0, K_START = 1, K_STOP = 2, K_SYNC = 3,
                 K_FSTOP = 4, K_FGO = 5, K_FERR = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b1;
  logic acq_start, acq_stop, sync_s, hold, ce, ferr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int r_cyc = 1 << 30;
  int evt_cyc = -1;
  int evt_kind = K_NONE;
  int hold_end = -1;
  int ls = 0;
  bit done = 1'b0;
  string cur_tag = "R11";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fcmd_rx #(.BIT_CYCLES(BIT), .DIV_CYCLES(DIV), .HOLD_CYCLES(HOLD)) i_fcmd_rx (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx),
    .acq_start_o(acq_start), .acq_stop_o(acq_stop), .sync_o(sync_s),
    .hold_o(hold), .ce_o(ce), .frame_err_o(ferr)
  );

  task automatic check(input string name, input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cyc=%0d actual=%b expected=%b", tag, name, cyc, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [15:0] w, input bit s1, input bit s2);
    if (!s1 || !s2) return K_FERR;
    case (w)
      16'hE311: return K_START;
      16'hE313: return K_STOP;
      16'hE000: return K_SYNC;
      16'hE519: return K_FSTOP;
      16'hE51A: return K_FGO;
      default:  return K_NONE;
    endcase
  endfunction

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (!done) begin
      int n;
      bit hit;
      n = cyc;
      if (!rst_ni || n < r_cyc) begin
        check("acq_start_o", acq_start, 1'b0, "R11");
        check("acq_stop_o", acq_stop, 1'b0, "R11");
        check("sync_o", sync_s, 1'b0, "R11");
        check("hold_o", hold, 1'b0, "R11");
        check("ce_o", ce, 1'b0, "R11");
        check("frame_err_o", ferr, 1'b0, "R11");
      end else begin
        hit = (n == evt_cyc);
        check("ce_o", ce, ((n - ls) % DIV) == DIV - 1, n - r_cyc < DIV ? "R11" : "R4");
        if (hit && evt_kind == K_FSTOP) hold_end = n + HOLD - 1;
        if (hit && evt_kind == K_FGO)   hold_end = n - 1;
        if (hit && evt_kind == K_SYNC)  ls = n + 1;
        check("acq_start_o", acq_start, hit && evt_kind == K_START, cur_tag);
        check("acq_stop_o", acq_stop, hit && evt_kind == K_STOP, cur_tag);
        check("sync_o", sync_s, hit && evt_kind == K_SYNC, cur_tag);
        check("frame_err_o", ferr, hit && evt_kind == K_FERR, cur_tag);
        check("hold_o", hold, n <= hold_end, cur_tag);
      end
    end
  end

  task automatic send_frame(input logic [15:0] w, input bit s1, input bit s2,
                            input string tag, input int gap);
    evt_cyc  = cyc + LAT;
    evt_kind = kind_of(w, s1, s2);
    cur_tag  = tag;
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rx = w[i];
      repeat (BIT) @(negedge clk);
    end
    rx = s1;
    repeat (BIT) @(negedge clk);
    rx = s2;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    r_cyc = cyc;
    ls = cyc;
    rst_ni = 1'b1;
    idle(20);
    send_frame(16'hE311, 1, 1, "R2 R1", GAP);
    send_frame(16'hE313, 1, 1, "R3", GAP);
    send_frame(16'hE000, 1, 1, "R4", GAP + 3);
    send_frame(16'hE312, 1, 1, "R8", GAP);
    send_frame(16'hE51B, 1, 1, "R8", GAP);
    send_frame(16'hE519, 1, 1, "R5", GAP);
    send_frame(16'h0000, 1, 1, "R7", GAP);
    idle(400);
    cur_tag = "R5";
    send_frame(16'hE519, 1, 1, "R5", GAP);
    send_frame(16'hE519, 1, 1, "R5", GAP);
    send_frame(16'hE51A, 1, 1, "R6", GAP);
    send_frame(16'hE311, 0, 1, "R9", GAP);
    send_frame(16'hE313, 1, 0, "R9", GAP);
    cur_tag = "R10";
    rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
    idle(3 * BIT);
    send_frame(16'hE000, 1, 1, "R4", 2);
    send_frame(16'hE311, 1, 1, "R2", GAP);
    idle(50);
    finish_run();
  end

  initial begin
    repeat (WD) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired at cyc=%0d actual=running expected=done", cyc);
    finish_run();
  end
endmodule